// File: doc/BRIEF.md
# Word-Serial Montgomery Reducer

This block reduces a double-width product T (2·QW bits) modulo an odd modulus q that is supplied at runtime alongside every product. It works on W-bit words: in each of L = ceil(QW/W) iterations it forms a quotient digit m = (T mod 2^W)·q' mod 2^W, where q' = −q⁻¹ mod 2^W, adds m·q so that the low word becomes zero, and drops that word. A single conditional subtraction of q at the end brings the value into [0, q). The result is therefore T·2^(−W·L) mod q. Removing that extra power-of-two factor is the caller's job, typically by multiplying with a precomputed constant.

The unit is a straight pipeline. One product may enter per clock, and each result leaves after a fixed latency. That latency is derived from the word count, from the per-word multiply-add latency and from an adder pipelining option. The modulus and q' travel down the pipe with their product, so neighbouring inputs may use different moduli.

Top module: `mont_word_reducer`

## Requirements
- R1: For odd q < 2^QW, T < q², and q' = −q⁻¹ mod 2^W supplied on `in_qinv`, the result equals T·2^(−W·L) mod q. With the defaults QW=64 and W=16, L=4, so the factor is 2^−64.
- R2: Every result is strictly below its modulus. This includes T = q (result 0) and T = (q−1)².
- R3: A result appears exactly LAT clock edges after the edge that captures its product, counting the capture edge as the first. LAT = L·MULLAT + A + (ADDPIP+1), where A = max(0,(2·QW−47)/W)·(ADDPIP+1) when QW−W ≤ 24 and A = L·(ADDPIP+1) otherwise. LAT is 9 for the defaults.
- R4: A new product is accepted on every clock with no stall, and results leave in input order.
- R5: `out_vld` is low during reset and stays low until a captured product emerges. A clock with `in_vld` low produces no result, and reset discards every product still in flight.
- R6: The modulus and q' are captured together with each product, so consecutive inputs may use different moduli.
- R7: Each word iteration leaves T + m·q with its low W bits zero before the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Product on `in_prod` is valid this cycle |
| in_prod | input | 2*QW | Product T to be reduced |
| in_mod | input | QW | Odd modulus q for this product |
| in_qinv | input | W | −q⁻¹ mod 2^W for this modulus |
| out_vld | output | 1 | `out_res` holds a result this cycle |
| out_res | output | QW | Reduced value in [0, q) |

## Verification
Every result is due a fixed nine edges after the edge that captures its product. The bench stamps each product with the edge count at which its result must appear. A monitor on the falling edge compares that stamp with the edge count when `out_vld` is seen, so a result that comes early or late fails R3 even when its value is right. Expected values come from a bit-serial halving model rather than from word steps. After every burst the bench waits past the latency and confirms that nothing is still owed and nothing extra came out.

// File: rtl/mont_red_pkg.sv
package mont_red_pkg;

  // number of W-bit word iterations needed to cover a QW-bit modulus
  function automatic int word_count(int qw, int w);
    return (qw + w - 1) / w;
  endfunction

  // cycles reserved for the wide carry-propagating adders
  function automatic int adder_lat(int qw, int w, int addpip);
    int base;
    if (qw - w <= 24) begin
      base = (2 * qw - 47) / w;
      if (base < 0) base = 0;
    end else begin
      base = word_count(qw, w);
    end
    return base * (addpip + 1);
  endfunction

  // end-to-end latency of the reducer
  function automatic int total_lat(int qw, int w, int mullat, int addpip);
    return word_count(qw, w) * mullat + adder_lat(qw, w, addpip) + (addpip + 1);
  endfunction

endpackage

// File: rtl/mont_pipe_dly.sv
module mont_pipe_dly #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_dat,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_dat
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign out_vld = in_vld;
      assign out_dat = in_dat;
    end else begin : g_regs
      logic             vld_q [DEPTH];
      logic [WIDTH-1:0] dat_q [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
        end else begin
          vld_q[0] <= in_vld;
          for (int i = 1; i < DEPTH; i++) vld_q[i] <= vld_q[i-1];
        end
      end

      always_ff @(posedge clk) begin
        dat_q[0] <= in_dat;
        for (int i = 1; i < DEPTH; i++) dat_q[i] <= dat_q[i-1];
      end

      assign out_vld = vld_q[DEPTH-1];
      assign out_dat = dat_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/mont_word_stage.sv
module mont_word_stage #(
  parameter int QW    = 64,
  parameter int W     = 16,
  parameter int TW    = 2 * QW + 1,
  parameter int DEPTH = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [TW-1:0] in_t,
  input  logic [QW-1:0] in_q,
  input  logic [W-1:0]  in_qi,
  output logic          out_vld,
  output logic [TW-1:0] out_t,
  output logic [QW-1:0] out_q,
  output logic [W-1:0]  out_qi
);

  localparam int PW = TW + QW + W;

  // quotient digit: low word times -q^-1, kept to W bits
  function automatic logic [W-1:0] quot_digit(logic [W-1:0] lo, logic [W-1:0] qi);
    logic [W-1:0] r;
    r = lo * qi;
    return r;
  endfunction

  // accumulate m*q so the low word cancels
  function automatic logic [TW:0] fold(logic [TW-1:0] t, logic [W-1:0] m, logic [QW-1:0] q);
    logic [TW:0] mq;
    mq = (TW+1)'(m) * (TW+1)'(q);
    return {1'b0, t} + mq;
  endfunction

  logic [W-1:0]  digit;
  logic [TW:0]   folded;
  logic [TW-1:0] shifted;
  logic          low_clear;
  logic [PW-1:0] pk_in, pk_out;

  assign digit     = quot_digit(in_t[W-1:0], in_qi);
  assign folded    = fold(in_t, digit, in_q);
  assign shifted   = TW'(folded >> W);
  assign low_clear = (folded[W-1:0] == '0);

  assign pk_in = {shifted, in_q, in_qi};

  mont_pipe_dly #(.WIDTH(PW), .DEPTH(DEPTH)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_dat  (pk_in),
    .out_vld (out_vld),
    .out_dat (pk_out)
  );

  assign {out_t, out_q, out_qi} = pk_out;

  // R7: the accumulated word must cancel before it is dropped
  assert_low_word_clear_R7: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> low_clear);

endmodule

// File: rtl/mont_final_sub.sv
module mont_final_sub #(
  parameter int QW    = 64,
  parameter int TW    = 2 * QW + 1,
  parameter int DEPTH = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [TW-1:0] in_t,
  input  logic [QW-1:0] in_q,
  output logic          out_vld,
  output logic [QW-1:0] out_res
);

  function automatic logic [QW-1:0] cond_sub(logic [TW-1:0] t, logic [QW-1:0] q);
    if (t >= TW'(q)) return QW'(t - TW'(q));
    return QW'(t);
  endfunction

  logic [QW-1:0]   res_c;
  logic [2*QW-1:0] pk_out;
  logic [QW-1:0]   q_dly;

  assign res_c = cond_sub(in_t, in_q);

  mont_pipe_dly #(.WIDTH(2 * QW), .DEPTH(DEPTH)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_dat  ({res_c, in_q}),
    .out_vld (out_vld),
    .out_dat (pk_out)
  );

  assign {out_res, q_dly} = pk_out;

  // R2: word iterations must leave less than 2q for one subtraction
  assert_pre_sub_bound_R2: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> (in_t < {TW'(in_q), 1'b0}));

  // R2: delivered result is fully reduced
  assert_result_below_q_R2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_res < q_dly));

endmodule

// File: rtl/mont_word_reducer.sv
module mont_word_reducer
  import mont_red_pkg::*;
#(
  parameter int QW     = 64,
  parameter int W      = 16,
  parameter int MULLAT = 1,
  parameter int ADDPIP = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [2*QW-1:0] in_prod,
  input  logic [QW-1:0]   in_mod,
  input  logic [W-1:0]    in_qinv,
  output logic            out_vld,
  output logic [QW-1:0]   out_res
);

  localparam int L   = word_count(QW, W);
  localparam int PAD = adder_lat(QW, W, ADDPIP);
  localparam int FIN = ADDPIP + 1;
  localparam int LAT = total_lat(QW, W, MULLAT, ADDPIP);
  localparam int TW  = 2 * QW + 1;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic          vld_c [L+1];
  logic [TW-1:0] t_c   [L+1];
  logic [QW-1:0] q_c   [L+1];
  logic [W-1:0]  qi_c  [L+1];

  assign vld_c[0] = in_vld;
  assign t_c[0]   = TW'(in_prod);
  assign q_c[0]   = in_mod;
  assign qi_c[0]  = in_qinv;

  generate
    for (genvar i = 0; i < L; i++) begin : g_word
      mont_word_stage #(.QW(QW), .W(W), .TW(TW), .DEPTH(MULLAT)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (vld_c[i]),
        .in_t    (t_c[i]),
        .in_q    (q_c[i]),
        .in_qi   (qi_c[i]),
        .out_vld (vld_c[i+1]),
        .out_t   (t_c[i+1]),
        .out_q   (q_c[i+1]),
        .out_qi  (qi_c[i+1])
      );
    end
  endgenerate

  logic          pad_vld;
  logic [TW-1:0] pad_t;
  logic [QW-1:0] pad_q;

  mont_pipe_dly #(.WIDTH(TW + QW), .DEPTH(PAD)) u_add_pad (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (vld_c[L]),
    .in_dat  ({t_c[L], q_c[L]}),
    .out_vld (pad_vld),
    .out_dat ({pad_t, pad_q})
  );

  mont_final_sub #(.QW(QW), .TW(TW), .DEPTH(FIN)) u_final (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (pad_vld),
    .in_t    (pad_t),
    .in_q    (pad_q),
    .out_vld (out_vld),
    .out_res (out_res)
  );

  // in-flight count used only by the checks below
  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(in_vld) - CW'(out_vld);
  end

  // R3: never more products inside than pipeline slots
  assert_latency_window_R3: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LAT));

  // R5: a result needs a captured product behind it
  assert_no_orphan_R5: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (inflight != '0));

  // R5: pipeline is empty right after reset
  assert_reset_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_vld);

  // R6: modulus and its inverse digit stay paired down the chain
  assert_qinv_paired_R6: assert property (@(posedge clk) disable iff (rst)
    vld_c[L] |-> (W'(q_c[L][W-1:0] * qi_c[L]) == {W{1'b1}}));

endmodule

// File: tb/mont_word_reducer_bench.sv
`timescale 1ns/1ps
module mont_word_reducer_bench;

  localparam int QW   = 64;
  localparam int W    = 16;
  localparam int LATX = 9;
  localparam int NV   = 10;

  localparam logic [63:0] QA = 64'h8000_0000_0008_0001;
  localparam logic [63:0] QG = 64'hFFFF_FFFF_0000_0001;
  localparam logic [63:0] QS = 64'd12289;
  localparam logic [63:0] QC = 64'hFFFF_FFFF_FFFF_FFC5;

  localparam logic [127:0] VT [NV] = '{
    128'h0123_4567_89AB_CDEF_0FED_CBA9_8765_4321,
    128'h3FFF_0000_1234_5678_9ABC_DEF0_1111_2222,
    128'hFFFF_FFFE_0000_0000_DEAD_BEEF_CAFE_F00D,
    128'h1,
    128'd150000000,
    128'd12288,
    128'h8765_4321_0FED_CBA9_0123_4567_89AB_CDEF,
    128'hFFFF_FFFF_FFFF_FF00_0000_0000_0000_0000,
    128'h0,
    128'd1000000
  };
  localparam logic [63:0] VQ [NV] = '{QA, QA, QG, QG, QS, QS, QC, QC, QA, QS};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_vld = 1'b0;
  logic [2*QW-1:0] in_prod = '0;
  logic [QW-1:0]   in_mod = '0;
  logic [W-1:0]    in_qinv = '0;
  logic            out_vld;
  logic [QW-1:0]   out_res;

  mont_word_reducer u_mont_word_reducer (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_prod(in_prod),
    .in_mod(in_mod), .in_qinv(in_qinv), .out_vld(out_vld), .out_res(out_res)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [63:0] exp_q [$];
  logic [63:0] mod_q [$];
  int          due_q [$];

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-serial model: halve 64 times, adding q whenever odd
  function automatic logic [63:0] ref_redc(logic [127:0] t, logic [63:0] q);
    logic [129:0] x;
    x = {2'b00, t};
    for (int i = 0; i < W * 4; i++) begin
      if (x[0]) x = x + {66'd0, q};
      x = x >> 1;
    end
    x = x % {66'd0, q};
    return x[63:0];
  endfunction

  // -q^-1 mod 2^16 by Newton steps
  function automatic logic [15:0] neg_inv(logic [63:0] q);
    logic [15:0] x;
    logic [15:0] q16;
    q16 = q[15:0];
    x = 16'd1;
    for (int i = 0; i < 5; i++) x = x * (16'd2 - q16 * x);
    return -x;
  endfunction

  task automatic send_exp(logic [127:0] t, logic [63:0] q, logic [63:0] e);
    @(negedge clk);
    in_vld  = 1'b1;
    in_prod = t;
    in_mod  = q;
    in_qinv = neg_inv(q);
    exp_q.push_back(e);
    mod_q.push_back(q);
    due_q.push_back(cyc + LATX);
  endtask

  task automatic send(logic [127:0] t, logic [63:0] q);
    send_exp(t, q, ref_redc(t, q));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  task automatic drain(string req);
    idle(LATX + 3);
    check(exp_q.size() == 0, req, 128'(exp_q.size()), 128'd0);
  endtask

  // monitor: value, bound and timing of every result
  always @(negedge clk) begin
    if (!rst && out_vld && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected result", 128'(out_res), 128'd0);
      end else begin
        logic [63:0] e;
        logic [63:0] m;
        int d;
        e = exp_q.pop_front();
        m = mod_q.pop_front();
        d = due_q.pop_front();
        check(out_res == e, "R1 R7 R6 value", 128'(out_res), 128'(e));
        check(out_res < m, "R2 below modulus", 128'(out_res), 128'(m));
        check(cyc == d, "R3 latency edge", 128'(cyc), 128'(d));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_vld == 1'b0, "R5 reset quiet", 128'(out_vld), 128'd0);
    rst = 1'b0;

    // table walk, back to back, moduli alternating
    for (int i = 0; i < NV; i++) send(VT[i], VQ[i]);
    drain("R4 R6 burst drained");

    // same table with gaps: idle clocks must add nothing
    for (int i = 0; i < NV; i++) begin
      send(VT[i], VQ[i]);
      idle(i % 3);
    end
    drain("R5 gapped drained");

    // directed corners with literal expectations
    send_exp(128'h1_0000_0000_0000_0000, QA, 64'd1);
    send_exp({64'd0, QG}, QG, 64'd0);
    send_exp(128'd0, QC, 64'd0);
    send(128'(QA - 1) * 128'(QA - 1), QA);
    send(128'(QC - 1) * 128'(QC - 1), QC);
    send(128'(QS - 1) * 128'(QS - 1), QS);
    drain("R2 corners drained");

    // reset with products in flight
    for (int i = 0; i < 5; i++) send(VT[i], VQ[i]);
    @(negedge clk);
    in_vld = 1'b0;
    rst = 1'b1;
    exp_q.delete();
    mod_q.delete();
    due_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < LATX + 4; i++) begin
        @(negedge clk);
        if (out_vld) seen++;
      end
      check(seen == 0, "R5 flush on reset", 128'(seen), 128'd0);
    end

    // pipeline still works after the flush
    send(VT[6], VQ[6]);
    send(VT[4], VQ[4]);
    drain("R4 after flush");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule